// File: doc/BRIEF.md
# Rename Stage Stall Controller

This block is the control state machine for one thread of a register-rename pipeline stage. Each cycle it accepts at most one instruction slot from decode. A slot is an opaque tag plus two flags: serialize-before and serialize-after. It forwards slots downstream when the stage is free to do so. The stage can be told to stop by a squash from commit, by a continuing reorder-buffer squash, or by an aggregate stall flag that stands for every later-stage and resource condition. In those cases the controller tells decode to stop sending by pulsing `block_o`, and it holds arriving slots in a skid buffer. When the stage can resume, it drains that buffer before it takes any fresh input, and it pulses `unblock_o` once the buffer is empty.

The block also handles serializing instructions. A slot marked serialize-before is kept back in a dedicated holding register, and the thread sits in a serialize-stall state until `pipe_drained_i` reports an empty reorder buffer with nothing in flight. A slot marked serialize-after causes the slot that follows it to be treated as serialize-before. That pending mark is dropped if the pipeline is already drained when it would apply.

The input has a valid but no ready. Back-pressure toward decode is edge-based: one `block_o` pulse starts a stop, and one `unblock_o` pulse ends it. Decode may keep sending slots for up to `BP_DELAY` cycles after a block, and the skid buffer (2·BP_DELAY+1 entries) absorbs them. The output is a valid/tag pair with no ready; downstream back-pressure arrives through `stall_i`.

Top module: `rename_stall_ctrl`

## Requirements
- R1: Synchronous active-low reset places the thread in Idle (`state_o` 0), empties the skid buffer and holding register, clears the pending mark, and drives `out_valid_o`, `block_o` and `unblock_o` low.
- R2: The `state_o` encoding is Idle=0, Running=1, Blocked=2, Unblocking=3, Squashing=4, SerStall=5. In Idle or Running with no stop condition, a valid slot appears on `out_valid_o`/`out_tag_o` one cycle later. The first valid slot moves Idle to Running.
- R3: With `stall_i` high and no squash, nothing is emitted. Arriving slots go into the skid buffer, except in Squashing, where they are dropped. Idle, Running and Squashing move to Blocked, and `block_o` pulses for one cycle.
- R4: Blocked moves to Unblocking on the first cycle without a stop condition. Unblocking emits buffered slots in arrival order, one per cycle, and appends new arrivals behind them. When the buffer empties, the thread moves to Running and `unblock_o` pulses.
- R5: A stall in Unblocking returns the thread to Blocked without a `block_o` pulse. A stall in Blocked stays in Blocked with no pulse.
- R6: `squash_i` has highest priority. It moves every state to Squashing, discards the buffered and held slots and the arriving slot, and pulses `unblock_o` only when leaving Blocked, Unblocking or SerStall.
- R7: `rob_squashing_i` (when there is no `squash_i`) keeps or places the thread in Squashing, drops all slots, and produces no handshake pulse. Squashing moves to Running on the first cycle with no stop condition, without emitting.
- R8: A serialize-before slot reaching the head in Idle, Running or Unblocking is not emitted. It is held, and the thread enters SerStall. `block_o` pulses unless the thread came from Unblocking.
- R9: In SerStall, `stall_i` keeps the thread in SerStall (with a `block_o` pulse). Once `pipe_drained_i` is high, the thread moves to Unblocking with the held slot, its serialize flag cleared, placed ahead of every buffered slot.
- R10: After a serialize-after slot is emitted, the next slot considered is treated as serialize-before if `pipe_drained_i` is low at that time. If `pipe_drained_i` is high at that time, or while no slot is waiting, the pending mark is dropped.
- R11: The skid buffer never holds more than 2·BP_DELAY+1 slots.
- R12: `block_o` and `unblock_o` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid_i | input | 1 | A slot from decode is present |
| in_tag_i | input | TAG_W | Opaque slot tag |
| in_ser_before_i | input | 1 | Slot must wait for an empty pipeline |
| in_ser_after_i | input | 1 | Slot serializes the slot that follows it |
| squash_i | input | 1 | Squash from commit |
| rob_squashing_i | input | 1 | Reorder buffer still squashing |
| stall_i | input | 1 | Aggregate later-stage or resource stall |
| pipe_drained_i | input | 1 | Reorder buffer empty and nothing in flight |
| out_valid_o | output | 1 | A slot is sent downstream |
| out_tag_o | output | TAG_W | Tag of the slot sent |
| block_o | output | 1 | Pulse: decode must stop |
| unblock_o | output | 1 | Pulse: decode may resume |
| state_o | output | 3 | Current state, encoded as in R2 |

## Verification
The bench targets the transitions that are easy to get wrong:
- A stall during Unblocking. A design that re-sent `block_o` there would double-count stops at decode.
- A stall during SerStall. Falling into Blocked there would lose the held slot.
- A squash out of a buffered state. A design that did not pulse `unblock_o` would leave decode frozen, and one that kept buffered slots would leak stale tags after the squash.
- The held slot must come out ahead of slots that arrived during the serialize stall. Dropping the pending serialize-after mark at the wrong time would stall needlessly, or fail to stall at all.

// File: rtl/rsc_pkg.sv
`timescale 1ns/1ps
package rsc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_RUN        = 3'd1,
    ST_BLOCKED    = 3'd2,
    ST_UNBLOCKING = 3'd3,
    ST_SQUASHING  = 3'd4,
    ST_SERSTALL   = 3'd5
  } rsc_state_e;
endpackage

// File: rtl/rsc_skid_buf.sv
`timescale 1ns/1ps
// Circular skid store; supports pop, push at the head and push at the tail.
module rsc_skid_buf #(
  parameter int W     = 10,
  parameter int DEPTH = 5,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             pop,
  input  logic             push_front,
  input  logic [W-1:0]     front_data,
  input  logic             push_back,
  input  logic [W-1:0]     back_data,
  output logic [W-1:0]     head_data,
  output logic [CNT_W-1:0] count
);
  logic [W-1:0]     mem [DEPTH];
  logic [IDX_W-1:0] head_q, head_d, tail_idx, front_idx;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  function automatic logic [IDX_W-1:0] idx_inc(input logic [IDX_W-1:0] i);
    return (int'(i) == DEPTH - 1) ? '0 : i + 1'b1;
  endfunction

  function automatic logic [IDX_W-1:0] idx_dec(input logic [IDX_W-1:0] i);
    return (i == '0) ? IDX_W'(DEPTH - 1) : i - 1'b1;
  endfunction

  always_comb begin
    int unsigned t;
    t = int'(head_q) + int'(cnt_q);
    if (t >= DEPTH) t = t - DEPTH;
    tail_idx  = IDX_W'(t);
    front_idx = idx_dec(head_q);
  end

  always_comb begin
    head_d = head_q;
    cnt_d  = cnt_q;
    if (clear) begin
      head_d = '0;
      cnt_d  = '0;
    end else begin
      if (pop)        head_d = idx_inc(head_q);
      if (push_front) head_d = front_idx;
      cnt_d = cnt_q + CNT_W'(push_front) + CNT_W'(push_back) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_d;
      cnt_q  <= cnt_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!clear && push_front && front_idx == IDX_W'(g))
        mem[g] <= front_data;
      else if (!clear && push_back && tail_idx == IDX_W'(g))
        mem[g] <= back_data;
    end
  end

  assign head_data = mem[head_q];
  assign count     = cnt_q;

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/rsc_ser_hold.sv
`timescale 1ns/1ps
// Holding register for a serializing slot plus the pending serialize mark.
module rsc_ser_hold #(
  parameter int HW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          load,
  input  logic [HW-1:0] load_data,
  output logic [HW-1:0] held_o,
  input  logic          pend_set,
  input  logic          pend_clr,
  output logic          pend_o
);
  logic [HW-1:0] held_q;
  logic          pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (clear)     held_q <= '0;
      else if (load) held_q <= load_data;
      if (pend_set)      pend_q <= 1'b1;
      else if (pend_clr) pend_q <= 1'b0;
    end
  end

  assign held_o = held_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/rsc_ctrl.sv
`timescale 1ns/1ps
// Next-state and datapath steering for one rename thread.
module rsc_ctrl
  import rsc_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int CNT_W = 3,
  localparam int EW = TAG_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [EW-1:0]    in_ent,
  input  logic             squash,
  input  logic             rob_sq,
  input  logic             stall,
  input  logic             drained,
  input  logic [CNT_W-1:0] skid_cnt,
  input  logic [EW-1:0]    skid_head,
  input  logic             pend,
  output rsc_state_e       state,
  output logic             emit,
  output logic [TAG_W-1:0] emit_tag,
  output logic             block_set,
  output logic             unblock_set,
  output logic             skid_clear,
  output logic             skid_pop,
  output logic             skid_pushf,
  output logic             skid_pushb,
  output logic             hold_clear,
  output logic             hold_load,
  output logic [EW-2:0]    hold_ent,
  output logic             pend_set,
  output logic             pend_clr
);
  rsc_state_e        state_q, state_d;
  logic              cand_v, from_skid, eff_sb;
  logic [EW-1:0]     cand;
  logic [CNT_W:0]    skid_left;

  always_comb begin
    state_d     = state_q;
    emit        = 1'b0;
    emit_tag    = '0;
    block_set   = 1'b0;
    unblock_set = 1'b0;
    skid_clear  = 1'b0;
    skid_pop    = 1'b0;
    skid_pushf  = 1'b0;
    skid_pushb  = 1'b0;
    hold_clear  = 1'b0;
    hold_load   = 1'b0;
    pend_set    = 1'b0;
    pend_clr    = 1'b0;
    eff_sb      = 1'b0;
    from_skid   = (state_q == ST_UNBLOCKING);
    cand_v      = from_skid ? (skid_cnt != '0) : in_valid;
    cand        = from_skid ? skid_head : in_ent;
    hold_ent    = cand[EW-2:0];

    if (squash) begin
      state_d     = ST_SQUASHING;
      unblock_set = (state_q == ST_BLOCKED) || (state_q == ST_UNBLOCKING) ||
                    (state_q == ST_SERSTALL);
      skid_clear  = 1'b1;
      hold_clear  = 1'b1;
      pend_clr    = 1'b1;
    end else if (rob_sq) begin
      state_d    = ST_SQUASHING;
      skid_clear = 1'b1;
      hold_clear = 1'b1;
      pend_clr   = 1'b1;
    end else if (stall) begin
      block_set = (state_q != ST_BLOCKED) && (state_q != ST_UNBLOCKING);
      if (state_q != ST_SERSTALL) state_d = ST_BLOCKED;
      skid_pushb = in_valid && (state_q != ST_SQUASHING);
    end else if (state_q == ST_BLOCKED) begin
      state_d    = ST_UNBLOCKING;
      skid_pushb = in_valid;
    end else if (state_q == ST_SQUASHING) begin
      state_d = ST_RUN;
    end else if (state_q == ST_SERSTALL) begin
      skid_pushb = in_valid;
      if (drained) begin
        state_d    = ST_UNBLOCKING;
        skid_pushf = 1'b1;
        hold_clear = 1'b1;
      end
    end else begin
      skid_pushb = from_skid && in_valid;
      if (cand_v) begin
        skid_pop = from_skid;
        eff_sb   = cand[EW-1] || (pend && !drained);
        pend_clr = pend;
        if (eff_sb) begin
          state_d   = ST_SERSTALL;
          hold_load = 1'b1;
          block_set = !from_skid;
        end else begin
          emit     = 1'b1;
          emit_tag = cand[TAG_W-1:0];
          pend_set = cand[EW-2];
        end
      end else if (pend && drained) begin
        pend_clr = 1'b1;
      end
      if (state_q == ST_IDLE && cand_v && !eff_sb) state_d = ST_RUN;
    end

    skid_left = {1'b0, skid_cnt} - {{CNT_W{1'b0}}, skid_pop} + {{CNT_W{1'b0}}, skid_pushb};
    if (state_q == ST_UNBLOCKING && state_d == ST_UNBLOCKING && skid_left == '0) begin
      state_d     = ST_RUN;
      unblock_set = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;

  assert_blocked_advances_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BLOCKED && !squash && !rob_sq && !stall) |=> state_q == ST_UNBLOCKING);

  assert_serstall_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SERSTALL && stall && !squash && !rob_sq) |=> state_q == ST_SERSTALL);

  assert_rob_squash_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rob_sq && !squash) |=> state_q == ST_SQUASHING);
endmodule

// File: rtl/rename_stall_ctrl.sv
`timescale 1ns/1ps
module rename_stall_ctrl
  import rsc_pkg::*;
#(
  parameter int TAG_W    = 8,
  parameter int BP_DELAY = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid_i,
  input  logic [TAG_W-1:0] in_tag_i,
  input  logic             in_ser_before_i,
  input  logic             in_ser_after_i,
  input  logic             squash_i,
  input  logic             rob_squashing_i,
  input  logic             stall_i,
  input  logic             pipe_drained_i,
  output logic             out_valid_o,
  output logic [TAG_W-1:0] out_tag_o,
  output logic             block_o,
  output logic             unblock_o,
  output logic [2:0]       state_o
);
  localparam int EW         = TAG_W + 2;
  localparam int SKID_DEPTH = 2 * BP_DELAY + 1;
  localparam int CNT_W      = $clog2(SKID_DEPTH + 1);

  logic [EW-1:0]    in_ent, skid_head;
  logic [EW-2:0]    held, hold_ent;
  logic [CNT_W-1:0] skid_cnt;
  logic             pend, emit, block_set, unblock_set;
  logic             skid_clear, skid_pop, skid_pushf, skid_pushb;
  logic             hold_clear, hold_load, pend_set, pend_clr;
  logic [TAG_W-1:0] emit_tag;
  rsc_state_e       state;

  assign in_ent = {in_ser_before_i, in_ser_after_i, in_tag_i};

  rsc_ctrl #(.TAG_W(TAG_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid_i), .in_ent(in_ent),
    .squash(squash_i), .rob_sq(rob_squashing_i), .stall(stall_i),
    .drained(pipe_drained_i), .skid_cnt(skid_cnt), .skid_head(skid_head),
    .pend(pend), .state(state), .emit(emit), .emit_tag(emit_tag),
    .block_set(block_set), .unblock_set(unblock_set),
    .skid_clear(skid_clear), .skid_pop(skid_pop), .skid_pushf(skid_pushf),
    .skid_pushb(skid_pushb), .hold_clear(hold_clear), .hold_load(hold_load),
    .hold_ent(hold_ent), .pend_set(pend_set), .pend_clr(pend_clr)
  );

  rsc_skid_buf #(.W(EW), .DEPTH(SKID_DEPTH)) u_skid (
    .clk(clk), .rst_n(rst_n), .clear(skid_clear), .pop(skid_pop),
    .push_front(skid_pushf), .front_data({1'b0, held}),
    .push_back(skid_pushb), .back_data(in_ent),
    .head_data(skid_head), .count(skid_cnt)
  );

  rsc_ser_hold #(.HW(EW - 1)) u_hold (
    .clk(clk), .rst_n(rst_n), .clear(hold_clear), .load(hold_load),
    .load_data(hold_ent), .held_o(held), .pend_set(pend_set),
    .pend_clr(pend_clr), .pend_o(pend)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      out_tag_o   <= '0;
      block_o     <= 1'b0;
      unblock_o   <= 1'b0;
    end else begin
      out_valid_o <= emit;
      out_tag_o   <= emit_tag;
      block_o     <= block_set;
      unblock_o   <= unblock_set && !block_set;
    end
  end

  assign state_o = state;

  assert_no_dual_handshake_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(block_o && unblock_o));

  assert_squash_silences_R6: assert property (@(posedge clk) disable iff (!rst_n)
    squash_i |=> (!out_valid_o && state_o == ST_SQUASHING));

  assert_stall_no_emit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> !out_valid_o);
endmodule

// File: tb/rename_stall_ctrl_bench.sv
`timescale 1ns/1ps
module rename_stall_ctrl_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       in_valid = 0, in_sb = 0, in_sa = 0, squash = 0, rob_sq = 0, stall = 0, drained = 1;
  logic [7:0] in_tag = '0;
  logic       out_valid, block, unblock;
  logic [7:0] out_tag;
  logic [2:0] state;

  rename_stall_ctrl u_rename_stall_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .in_tag_i(in_tag),
    .in_ser_before_i(in_sb), .in_ser_after_i(in_sa), .squash_i(squash),
    .rob_squashing_i(rob_sq), .stall_i(stall), .pipe_drained_i(drained),
    .out_valid_o(out_valid), .out_tag_o(out_tag), .block_o(block),
    .unblock_o(unblock), .state_o(state)
  );

  int tests = 0, fails = 0;
  string cur_req = "R1";

  task automatic chk(string req, string what, int got, int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // Behavioural reference model
  localparam int S_IDLE = 0, S_RUN = 1, S_BLK = 2, S_UNB = 3, S_SQ = 4, S_SER = 5;
  bit [9:0] mq[$];
  bit [9:0] m_hold;
  bit       m_pend;
  int       m_state;
  bit       e_v, e_b, e_u;
  bit [7:0] e_tag;

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); m_hold = '0; m_pend = 0; m_state = S_IDLE;
      e_v = 0; e_b = 0; e_u = 0; e_tag = '0;
    end else begin
      automatic int s = m_state;
      automatic int ns = m_state;
      automatic bit [9:0] ent = {in_sb, in_sa, in_tag};
      automatic bit nv = 0, nb = 0, nu = 0, has = 0, sbv = 0;
      automatic bit [7:0] nt = '0;
      automatic bit [9:0] c = '0;
      if (squash) begin
        nu = (s == S_BLK || s == S_UNB || s == S_SER);
        mq.delete(); m_pend = 0; ns = S_SQ;
      end else if (rob_sq) begin
        mq.delete(); m_pend = 0; ns = S_SQ;
      end else if (stall) begin
        nb = !(s == S_BLK || s == S_UNB);
        if (s != S_SER) ns = S_BLK;
        if (in_valid && s != S_SQ) mq.push_back(ent);
      end else if (s == S_BLK) begin
        ns = S_UNB;
        if (in_valid) mq.push_back(ent);
      end else if (s == S_SQ) begin
        ns = S_RUN;
      end else if (s == S_SER) begin
        if (drained) begin
          mq.push_front({1'b0, m_hold[8:0]});
          ns = S_UNB;
        end
        if (in_valid) mq.push_back(ent);
      end else begin
        if (s == S_UNB) begin
          has = (mq.size() > 0);
          if (has) c = mq.pop_front();
          if (in_valid) mq.push_back(ent);
        end else begin
          has = in_valid;
          c = ent;
        end
        if (has) begin
          sbv = c[9] | (m_pend & !drained);
          m_pend = 0;
          if (sbv) begin
            m_hold = c; ns = S_SER; nb = (s != S_UNB);
          end else begin
            nv = 1; nt = c[7:0];
            if (c[8]) m_pend = 1;
          end
        end else if (m_pend && drained) begin
          m_pend = 0;
        end
        if (s == S_UNB && ns == S_UNB && mq.size() == 0) begin
          ns = S_RUN; nu = 1;
        end
        if (s == S_IDLE && has && !sbv) ns = S_RUN;
      end
      m_state = ns; e_v = nv; e_tag = nt; e_b = nb; e_u = nu;
    end
  end

  // Compare against the model every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(cur_req, "state", int'(state), m_state);
      chk(cur_req, "out_valid", int'(out_valid), int'(e_v));
      if (e_v) chk(cur_req, "out_tag", int'(out_tag), int'(e_tag));
      chk(cur_req, "block", int'(block), int'(e_b));
      chk(cur_req, "unblock", int'(unblock), int'(e_u));
      chk("R12", "block&unblock", int'(block & unblock), 0);
    end
  end

  task automatic tick(bit v, bit [7:0] t, bit sb, bit sa, bit st, bit sq, bit rs, bit dr);
    @(negedge clk);
    in_valid = v; in_tag = t; in_sb = sb; in_sa = sa;
    stall = st; squash = sq; rob_sq = rs; drained = dr;
    @(posedge clk);
    #1;
  endtask

  task automatic idle(int n, bit dr);
    for (int i = 0; i < n; i++) tick(0, 8'h00, 0, 0, 0, 0, 0, dr);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all): cycles got 20000 expected fewer");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1", "state", int'(state), 0);
    chk("R1", "out_valid", int'(out_valid), 0);
    chk("R1", "block", int'(block), 0);
    chk("R1", "unblock", int'(unblock), 0);
    @(negedge clk); rst_n = 1'b1;

    cur_req = "R2";
    tick(1, 8'd1, 0, 0, 0, 0, 0, 1);
    chk("R2", "state", int'(state), 1);
    chk("R2", "out_tag", int'(out_tag), 1);
    tick(1, 8'd2, 0, 0, 0, 0, 0, 1);
    tick(1, 8'd3, 0, 0, 0, 0, 0, 1);
    chk("R2", "out_tag", int'(out_tag), 3);
    idle(1, 1);

    cur_req = "R3";
    tick(1, 8'd10, 0, 0, 1, 0, 0, 1);
    chk("R3", "state", int'(state), 2);
    chk("R3", "block", int'(block), 1);
    chk("R3", "out_valid", int'(out_valid), 0);
    tick(1, 8'd11, 0, 0, 1, 0, 0, 1);
    chk("R5", "block repeat", int'(block), 0);
    cur_req = "R4";
    tick(1, 8'd12, 0, 0, 0, 0, 0, 1);
    chk("R4", "state", int'(state), 3);
    tick(0, 8'd0, 0, 0, 0, 0, 0, 1);
    chk("R4", "out_tag", int'(out_tag), 10);
    idle(2, 1);
    chk("R4", "out_tag", int'(out_tag), 12);
    chk("R4", "unblock", int'(unblock), 1);
    chk("R4", "state", int'(state), 1);

    cur_req = "R5";
    tick(1, 8'd20, 0, 0, 1, 0, 0, 1);
    tick(1, 8'd21, 0, 0, 0, 0, 0, 1);
    tick(0, 8'd0, 0, 0, 1, 0, 0, 1);
    chk("R5", "state", int'(state), 2);
    chk("R5", "block", int'(block), 0);
    idle(4, 1);

    cur_req = "R6";
    tick(1, 8'd30, 0, 0, 1, 0, 0, 1);
    tick(1, 8'd31, 0, 0, 0, 0, 0, 1);
    tick(1, 8'd32, 0, 0, 0, 1, 0, 1);
    chk("R6", "state", int'(state), 4);
    chk("R6", "unblock", int'(unblock), 1);
    tick(0, 8'd0, 0, 0, 0, 0, 0, 1);
    chk("R7", "out_valid", int'(out_valid), 0);
    tick(1, 8'd33, 0, 0, 0, 0, 0, 1);
    chk("R6", "out_tag", int'(out_tag), 33);

    cur_req = "R7";
    tick(1, 8'd40, 0, 0, 0, 0, 1, 1);
    chk("R7", "unblock", int'(unblock), 0);
    tick(1, 8'd41, 0, 0, 0, 0, 1, 1);
    chk("R7", "state", int'(state), 4);
    tick(1, 8'd42, 0, 0, 0, 0, 0, 1);
    chk("R7", "out_valid", int'(out_valid), 0);
    tick(1, 8'd43, 0, 0, 0, 0, 0, 1);
    chk("R7", "out_tag", int'(out_tag), 43);

    cur_req = "R8";
    tick(1, 8'd50, 1, 0, 0, 0, 0, 0);
    chk("R8", "state", int'(state), 5);
    chk("R8", "block", int'(block), 1);
    tick(1, 8'd51, 0, 0, 0, 0, 0, 0);
    cur_req = "R9";
    tick(0, 8'd0, 0, 0, 1, 0, 0, 0);
    chk("R9", "state", int'(state), 5);
    idle(1, 0);
    tick(0, 8'd0, 0, 0, 0, 0, 0, 1);
    chk("R9", "state", int'(state), 3);
    idle(1, 1);
    chk("R9", "out_tag", int'(out_tag), 50);
    idle(1, 1);
    chk("R9", "out_tag", int'(out_tag), 51);

    cur_req = "R10";
    tick(1, 8'd60, 0, 1, 0, 0, 0, 0);
    tick(1, 8'd61, 0, 0, 0, 0, 0, 0);
    chk("R10", "state", int'(state), 5);
    idle(2, 1);
    chk("R10", "out_tag", int'(out_tag), 61);
    tick(1, 8'd70, 0, 1, 0, 0, 0, 1);
    idle(1, 1);
    tick(1, 8'd71, 0, 0, 0, 0, 0, 0);
    chk("R10", "out_valid", int'(out_valid), 1);
    chk("R10", "out_tag", int'(out_tag), 71);
    tick(1, 8'd72, 0, 1, 0, 0, 0, 1);
    tick(1, 8'd73, 0, 0, 0, 0, 0, 1);
    chk("R10", "out_tag", int'(out_tag), 73);

    cur_req = "R8";
    tick(1, 8'd90, 0, 0, 1, 0, 0, 1);
    tick(1, 8'd91, 1, 0, 0, 0, 0, 0);
    idle(1, 0);
    idle(1, 0);
    chk("R8", "state from unblocking", int'(state), 5);
    chk("R8", "block from unblocking", int'(block), 0);
    idle(3, 1);

    cur_req = "R11";
    for (int k = 0; k < 5; k++) tick(1, 8'(80 + k), 0, 0, 1, 0, 0, 1);
    idle(7, 1);
    chk("R11", "state", int'(state), 1);

    cur_req = "R12";
    idle(3, 1);
    finish_run();
  end
endmodule